// File: doc/BRIEF.md
# Multilevel Feedback Thread Scheduler

This block decides which of a fixed set of hardware thread slots owns the processor next. Every slot carries a priority level. Level 0 is the top (foreground) level. Each level has its own time quantum, and the quantum doubles at each step down: level k lasts 2^k tick pulses. A thread that burns through its entire quantum drops one level. A thread that gives up the processor early, by a yield pulse or by dropping its ready flag, climbs one level. Compute-bound threads therefore sink, and threads that block often stay near the top.

Dispatch is non-preemptive. When no thread is running, the scheduler takes the highest level that holds a ready thread. Within that level it picks a thread in round-robin order, loads the quantum counter for that level and raises run-valid on the next cycle. An admit pulse for a slot places that slot back at the top level, which is how a newly created thread enters.

Top module: `mlfq_sched`

## Requirements
- R1: After reset, every thread is at level 0, each level's round-robin pointer is at thread 0, and `run_valid_o` is 0.
- R2: When no thread is running and at least one thread is ready, a thread is dispatched at that clock edge. From the next cycle `run_valid_o` is 1, `run_id_o` gives the thread index and `run_level_o` gives its level, where 0 is the highest priority.
- R3: A running thread at level k that is not released stays running for exactly 2^k tick pulses. On the tick that ends its quantum it is demoted by one level, saturating at level NUM_LEVELS-1, and `run_valid_o` is 0 in the following cycle.
- R4: When the running thread yields (`yield_i` high) or its ready flag is low, it is released and promoted by one level, saturating at 0. `run_valid_o` is 0 in the following cycle. A yield in the same cycle as the expiring tick counts as a yield.
- R5: At dispatch, no ready thread sits at a level numerically lower than the level of the chosen thread.
- R6: Within a level, the search starts at the thread after the one last dispatched from that level. It proceeds upward by index and wraps from thread NUM_THREADS-1 to thread 0.
- R7: A dispatched thread keeps `run_id_o` and `run_level_o` unchanged until it is released or its quantum expires. Ready threads at higher levels do not preempt it.
- R8: While no thread is ready, `run_valid_o` stays 0, and tick pulses change no thread's level.
- R9: `admit_i[t]` sets thread t's level to 0 at the next edge. This overrides a promotion or demotion of thread t in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | NUM_THREADS | Per-thread ready flags |
| yield_i | input | 1 | Running thread gives up the processor |
| tick_i | input | 1 | Quantum time unit pulse |
| admit_i | input | NUM_THREADS | Per-thread admit pulse, resets level to top |
| run_valid_o | output | 1 | A thread is running |
| run_id_o | output | $clog2(NUM_THREADS) | Index of running thread |
| run_level_o | output | $clog2(NUM_LEVELS) | Level the running thread was dispatched at |

## Verification
The hardest state to reach is a thread that has sunk to the bottom level and then has to show saturation. Reaching it takes 1+2+4+8 uninterrupted ticks with no yield and no other thread competing. Directed sequences hold a single thread ready with ticks on every cycle until it reaches level 3. They then combine a yield with an admit in one cycle to expose the precedence rule. A seeded random phase follows, with a slowly changing ready mask, occasional yields and occasional admits. A bench model of the requirements predicts the outputs every cycle during this phase, which covers round-robin wrap at each level.

// File: rtl/mlfq_pkg.sv
package mlfq_pkg;
  localparam int unsigned DefThreads = 8;
  localparam int unsigned DefLevels  = 4;
endpackage

// File: rtl/mlfq_level_table.sv
module mlfq_level_table #(
  parameter int unsigned N  = 8,
  parameter int unsigned L  = 4,
  parameter int unsigned IW = 3,
  parameter int unsigned LW = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         admit_i,
  input  logic                 upd_en_i,
  input  logic [IW-1:0]        upd_id_i,
  input  logic                 upd_demote_i,
  output logic [N-1:0][LW-1:0] levels_o
);
  localparam logic [LW-1:0] Bottom = LW'(L - 1);

  for (genvar t = 0; t < N; t++) begin : g_thr
    logic hit;
    assign hit = upd_en_i && (upd_id_i == IW'(t));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) levels_o[t] <= '0;
      else if (admit_i[t]) levels_o[t] <= '0;
      else if (hit) begin
        if (upd_demote_i) levels_o[t] <= (levels_o[t] == Bottom) ? Bottom : levels_o[t] + 1'b1;
        else              levels_o[t] <= (levels_o[t] == '0) ? '0 : levels_o[t] - 1'b1;
      end
    end

    // R8: level only moves on a release/expiry of this thread or an admit
    a_r8_level_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!admit_i[t] && !hit) |=> $stable(levels_o[t]));
    // R3: demotion is a single step when not at the bottom
    a_r3_demote_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && upd_demote_i && !admit_i[t] && levels_o[t] != Bottom)
      |=> levels_o[t] == $past(levels_o[t]) + 1'b1);
    // R9: admit wins
    a_r9_admit_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
      admit_i[t] |=> levels_o[t] == '0);
  end
endmodule

// File: rtl/mlfq_picker.sv
module mlfq_picker #(
  parameter int unsigned N  = 8,
  parameter int unsigned L  = 4,
  parameter int unsigned IW = 3,
  parameter int unsigned LW = 2
) (
  input  logic [N-1:0]         ready_i,
  input  logic [N-1:0][LW-1:0] levels_i,
  input  logic [L-1:0][IW-1:0] rr_i,
  output logic                 found_o,
  output logic [IW-1:0]        pick_id_o,
  output logic [LW-1:0]        pick_lvl_o
);
  always_comb begin
    found_o    = 1'b0;
    pick_id_o  = '0;
    pick_lvl_o = '0;
    for (int l = 0; l < L; l++) begin
      for (int k = 0; k < N; k++) begin
        int idx;
        idx = (int'(rr_i[l]) + k) % N;
        if (!found_o && ready_i[idx] && levels_i[idx] == LW'(l)) begin
          found_o    = 1'b1;
          pick_id_o  = IW'(idx);
          pick_lvl_o = LW'(l);
        end
      end
    end
  end
endmodule

// File: rtl/mlfq_quantum.sv
module mlfq_quantum #(
  parameter int unsigned L  = 4,
  parameter int unsigned LW = 2,
  parameter int unsigned QW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [LW-1:0] load_lvl_i,
  input  logic          run_i,
  input  logic          tick_i,
  output logic          expire_o
);
  logic [QW-1:0] left_q;

  assign expire_o = run_i && tick_i && (left_q == QW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    left_q <= '0;
    else if (load_i)                left_q <= QW'(1) << load_lvl_i;
    else if (run_i && tick_i && left_q != QW'(1)) left_q <= left_q - 1'b1;
  end

  // R3: a running thread never holds an empty quantum
  a_r3_quantum_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> left_q != '0);
endmodule

// File: rtl/mlfq_sched.sv
module mlfq_sched
  import mlfq_pkg::*;
#(
  parameter int unsigned NUM_THREADS = DefThreads,
  parameter int unsigned NUM_LEVELS  = DefLevels,
  localparam int unsigned IW = $clog2(NUM_THREADS),
  localparam int unsigned LW = $clog2(NUM_LEVELS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_THREADS-1:0] ready_i,
  input  logic                   yield_i,
  input  logic                   tick_i,
  input  logic [NUM_THREADS-1:0] admit_i,
  output logic                   run_valid_o,
  output logic [IW-1:0]          run_id_o,
  output logic [LW-1:0]          run_level_o
);
  localparam int unsigned QW = NUM_LEVELS;

  logic [NUM_THREADS-1:0][LW-1:0] levels;
  logic [NUM_LEVELS-1:0][IW-1:0]  rr_q;
  logic          cur_valid_q;
  logic [IW-1:0] cur_id_q;
  logic [LW-1:0] cur_lvl_q;
  logic          found, expire, release_run, timeout, dispatch;
  logic [IW-1:0] pick_id, next_ptr;
  logic [LW-1:0] pick_lvl;

  assign release_run = cur_valid_q && (yield_i || !ready_i[cur_id_q]);
  assign timeout     = expire && !release_run;
  assign dispatch    = !cur_valid_q && found;
  assign next_ptr    = (pick_id == IW'(NUM_THREADS - 1)) ? '0 : pick_id + 1'b1;

  mlfq_level_table #(.N(NUM_THREADS), .L(NUM_LEVELS), .IW(IW), .LW(LW)) u_levels (
    .clk_i, .rst_ni, .admit_i,
    .upd_en_i(release_run || timeout), .upd_id_i(cur_id_q), .upd_demote_i(timeout),
    .levels_o(levels)
  );

  mlfq_picker #(.N(NUM_THREADS), .L(NUM_LEVELS), .IW(IW), .LW(LW)) u_pick (
    .ready_i, .levels_i(levels), .rr_i(rr_q),
    .found_o(found), .pick_id_o(pick_id), .pick_lvl_o(pick_lvl)
  );

  mlfq_quantum #(.L(NUM_LEVELS), .LW(LW), .QW(QW)) u_quant (
    .clk_i, .rst_ni, .load_i(dispatch), .load_lvl_i(pick_lvl),
    .run_i(cur_valid_q), .tick_i, .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_valid_q <= 1'b0;
      cur_id_q    <= '0;
      cur_lvl_q   <= '0;
      rr_q        <= '0;
    end else if (dispatch) begin
      cur_valid_q    <= 1'b1;
      cur_id_q       <= pick_id;
      cur_lvl_q      <= pick_lvl;
      rr_q[pick_lvl] <= next_ptr;
    end else if (release_run || timeout) begin
      cur_valid_q <= 1'b0;
    end
  end

  assign run_valid_o = cur_valid_q;
  assign run_id_o    = cur_id_q;
  assign run_level_o = cur_lvl_q;

  logic higher_ready;
  always_comb begin
    higher_ready = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++)
      if (ready_i[t] && levels[t] < pick_lvl) higher_ready = 1'b1;
  end

  a_r2_pick_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispatch |-> ready_i[pick_id] && levels[pick_id] == pick_lvl);
  a_r5_no_higher: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispatch |-> !higher_ready);
  a_r7_hold_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_valid_q && !release_run && !timeout) |=> run_valid_o && $stable(run_id_o) && $stable(run_level_o));
  a_r4_release_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_run |=> !run_valid_o);
  a_r8_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|ready_i) |=> !run_valid_o);
endmodule

// File: tb/mlfq_sched_bench.sv
module mlfq_sched_bench;
  localparam int N = 8;
  localparam int L = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] ready_i = '0;
  logic yield_i = 1'b0;
  logic tick_i = 1'b0;
  logic [N-1:0] admit_i = '0;
  logic run_valid_o;
  logic [2:0] run_id_o;
  logic [1:0] run_level_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_lvl [N];
  int m_rr [L];
  bit m_valid;
  int m_id, m_cl, m_q;

  always #5ns clk_i = ~clk_i;

  mlfq_sched u_mlfq_sched (.*);

  task automatic model_step(input logic [N-1:0] rdy, input logic yld, input logic tck,
                            input logic [N-1:0] adm);
    bit hit;
    if (m_valid) begin
      if (yld || !rdy[m_id]) begin
        if (m_lvl[m_id] > 0) m_lvl[m_id]--;
        m_valid = 0;
      end else if (tck) begin
        if (m_q == 1) begin
          if (m_lvl[m_id] < L - 1) m_lvl[m_id]++;
          m_valid = 0;
        end else m_q--;
      end
    end else begin
      hit = 0;
      for (int l = 0; l < L; l++)
        for (int k = 0; k < N; k++) begin
          int idx;
          idx = (m_rr[l] + k) % N;
          if (!hit && rdy[idx] && m_lvl[idx] == l) begin
            hit = 1; m_valid = 1; m_id = idx; m_cl = l; m_q = 1 << l;
            m_rr[l] = (idx + 1) % N;
          end
        end
    end
    for (int t = 0; t < N; t++) if (adm[t]) m_lvl[t] = 0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    checks++;
    if (run_valid_o != m_valid || (m_valid && (run_id_o != m_id || run_level_o != m_cl))) begin
      failures++;
      $display("FAIL R2 R5 R6 R7 model: actual v=%0d id=%0d lvl=%0d expected v=%0d id=%0d lvl=%0d",
               run_valid_o, run_id_o, run_level_o, m_valid, m_id, m_cl);
    end
  endtask

  task automatic cyc(input logic [N-1:0] rdy, input logic yld, input logic tck,
                     input logic [N-1:0] adm);
    ready_i = rdy; yield_i = yld; tick_i = tck; admit_i = adm;
    @(posedge clk_i);
    model_step(rdy, yld, tck, adm);
    @(negedge clk_i);
    cmp_model();
  endtask

  initial begin
    #(200000 * 10ns);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    logic [N-1:0] rr_mask;
    sd = $urandom(32'd4321);
    for (int t = 0; t < N; t++) m_lvl[t] = 0;
    for (int l = 0; l < L; l++) m_rr[l] = 0;
    m_valid = 0; m_id = 0; m_cl = 0; m_q = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1 reset valid", run_valid_o, 0);

    cyc(8'h08, 0, 0, 0);
    chk("R1 R2 first dispatch valid", run_valid_o, 1);
    chk("R2 id", run_id_o, 3);
    chk("R1 starts at top level", run_level_o, 0);
    cyc(8'h08, 0, 1, 0);
    chk("R3 level0 quantum one tick", run_valid_o, 0);
    cyc(8'h08, 0, 0, 0);
    chk("R3 demoted to 1", run_level_o, 1);
    cyc(8'h08, 0, 1, 0);
    chk("R3 level1 still running after 1 tick", run_valid_o, 1);
    cyc(8'h08, 0, 1, 0);
    chk("R3 level1 expires after 2 ticks", run_valid_o, 0);
    cyc(8'h08, 1, 0, 0);
    chk("R3 demoted to 2", run_level_o, 2);
    cyc(8'h08, 1, 1, 0);
    chk("R4 yield releases", run_valid_o, 0);
    cyc(8'h08, 0, 0, 0);
    chk("R4 promoted to 1", run_level_o, 1);
    cyc(8'h08, 0, 1, 0);
    cyc(8'h08, 0, 1, 0);
    cyc(8'h28, 0, 0, 0);
    chk("R5 higher level thread chosen", run_id_o, 5);
    cyc(8'h28, 0, 1, 0);
    cyc(8'h28, 0, 0, 0);
    chk("R5 level1 beats level2", run_id_o, 5);
    chk("R5 level", run_level_o, 1);
    cyc(8'h03, 0, 0, 0);
    chk("R4 ready drop releases", run_valid_o, 0);
    cyc(8'h03, 0, 0, 0);
    chk("R6 search after last granted wraps to 0", run_id_o, 0);
    cyc(8'h03, 1, 0, 0);
    cyc(8'h03, 0, 0, 0);
    chk("R6 next in turn", run_id_o, 1);
    cyc(8'h03, 1, 0, 0);
    cyc(8'h03, 0, 0, 0);
    chk("R6 wrap", run_id_o, 0);

    for (int i = 0; i < 40; i++) cyc(8'h01, 0, 1, 0);
    for (int i = 0; i < 3 && !run_valid_o; i++) cyc(8'h01, 0, 0, 0);
    chk("R3 bottom saturation level", run_level_o, 3);
    cyc(8'h01, 1, 0, 8'h01);
    chk("R9 released", run_valid_o, 0);
    cyc(8'h01, 0, 0, 0);
    chk("R9 admit overrides promote", run_level_o, 0);

    for (int i = 0; i < 5; i++) begin
      cyc(8'h00, 0, 1, 0);
      chk("R8 idle no run", run_valid_o, 0);
    end
    cyc(8'h01, 0, 0, 0);
    chk("R8 idle ticks kept level", run_level_o, 0);

    rr_mask = 8'hA5;
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] adm;
      if ($urandom % 4 == 0) rr_mask = N'($urandom);
      adm = ($urandom % 12 == 0) ? N'(1 << ($urandom % N)) : '0;
      cyc(rr_mask, ($urandom % 6 == 0), ($urandom % 2 == 1), adm);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule